// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the front end of a transmit DMA engine. It walks a linked list of four-word descriptors held in memory, reaching them through a simple word-wide read/write port. The host first loads the address of the first descriptor. It then issues a poll strobe. For every descriptor the device owns, the walker hands the buffer address and byte length to a downstream frame mover. It waits for that mover to report completion with a status code. It then writes a condensed status word back over the first word of the descriptor, with the ownership bit cleared.

After each write-back the walker moves on without any host action. If the control word selects chained addressing, the next address is the link word. Otherwise it is the next sequential 16-byte slot. When it fetches a descriptor the host still owns, it stops at that address and raises a suspended flag. A later poll restarts it at the same descriptor. Laying the chain out as a ring, with the last link pointing back to the first entry, lets the host refill entries and poll again indefinitely. Frame data movement and the MAC are outside this block.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset the walker is idle: busy, suspended, irq, mem_req and mv_req are all low.
- R2: A base_wr pulse while idle loads the current descriptor pointer. A poll_wr pulse while idle or suspended starts a read of word 0 at that pointer; this request is visible one cycle later with busy high.
- R3: When word 0 bit 31 (ownership) reads as 0, the walker issues no further memory or mover request and raises suspended. It leaves the descriptor unmodified and keeps its pointer, so the next poll fetches the same address.
- R4: For an owned descriptor the walker reads word 1 (control) at pointer+4, word 2 (buffer address) at +8 and word 3 (link) at +12. It then presents mv_addr equal to word 2 and mv_len equal to word 1 bits 10:0.
- R5: A descriptor with a length field of zero produces no mover request and is written back with word 0 equal to 0.
- R6: Write-back is a single write to word 0 of the descriptor with bit 31 clear. Bits 14:0 hold the completion status ANDed with 0x4302; bit 1 of the status, the transmit underrun flag, is therefore kept. Bit 15 is an error summary, set when any masked bit is set. Bits 31:16 are 0.
- R7: irq pulses high for exactly one cycle after the write-back of a descriptor whose word 1 bit 31 is set, and never otherwise.
- R8: After a write-back the walker fetches the next descriptor without a new poll. The next address is word 3 when word 1 bit 24 is set, and pointer+16 when it is clear.
- R9: A memory request holds its address, direction and data until mem_ack. A mover request holds its address and length until mv_done. The two are never active together.
- R10: busy stays high from the start of a walk until the walker suspends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Load pointer strobe (taken only when idle) |
| base_addr | input | 32 | First descriptor address |
| poll_wr | input | 1 | Poll demand strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Frame transfer request |
| mv_addr | output | 32 | Frame buffer address |
| mv_len | output | 11 | Frame byte length |
| mv_done | input | 1 | Transfer finished, status valid |
| mv_status | input | 16 | Raw completion status |
| irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | Walk in progress |
| suspended | output | 1 | Stopped on a host-owned descriptor |

## Verification
A corrupted state register or word-offset shows up within one memory access as a wrong mem_addr. The descriptor write-back then lands in the wrong word, and the bench finds it when it reads the ring after the walk. A wrong captured control or buffer word shows up at the mover request, as a bad length or a buffer address pointing at a different slot. A wrong pointer update moves the suspension point, so the next poll fetches from an unexpected address. The bench checks that address in the cycle after the poll.

// File: rtl/tdw_pkg.sv
// Package: shared state type and descriptor bit positions for the walker.
// Assumes descriptors are four little-endian 32-bit words on 16-byte bounds.
package tdw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_MOVE, S_WB
    } walk_state_t;

    localparam int unsigned OWN_BIT   = 31;
    localparam int unsigned IRQ_BIT   = 31;
    localparam int unsigned CHAIN_BIT = 24;
endpackage

// File: rtl/tdw_ptr.sv
// Current-descriptor pointer register.
// Assumes load and advance are never requested in the same cycle.
module tdw_ptr #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic [AW-1:0] adv_val,
    output logic [AW-1:0] cur
);
    // Hold the pointer; host load or walk advance replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur <= '0;
        else if (load)  cur <= load_val;
        else if (adv)   cur <= adv_val;
    end

    p_ptr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && adv));
endmodule

// File: rtl/tdw_status.sv
// Condenses the mover's raw status into the descriptor word-0 format:
// masked error bits low, error summary at bit 15, ownership clear.
module tdw_status #(
    parameter int unsigned SW   = 16,
    parameter logic [15:0] MASK = 16'h4302
) (
    input  logic [SW-1:0] raw,
    output logic [31:0]   word
);
    logic [15:0] kept;

    // Mask raw status and build the summary bit.
    always_comb begin
        kept = 16'(raw) & MASK;
        word = {16'h0000, |kept, kept[14:0]};
    end
endmodule

// File: rtl/tdw_fsm.sv
// Walk sequencer: fetches descriptor words, hands work to the mover,
// writes status back and computes the next pointer.
// Assumes memory read data is valid in the cycle mem_ack is high.
module tdw_fsm
    import tdw_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_wr,
    input  logic [AW-1:0]    cur_ptr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mv_done,
    input  logic [31:0]      fmt_word,
    output logic             mem_req,
    output logic             mem_we,
    output logic [3:0]       mem_off,
    output logic [31:0]      mem_wdata,
    output logic             mv_req,
    output logic [AW-1:0]    mv_addr,
    output logic [LEN_W-1:0] mv_len,
    output logic             adv,
    output logic [AW-1:0]    adv_val,
    output logic             irq,
    output logic             suspended,
    output logic             busy
);
    localparam logic [AW-1:0] DESC_BYTES = AW'(16);

    walk_state_t state;
    logic [31:0] ctl_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] link_q;
    logic [31:0] stat_q;

    // Sequence state, capture descriptor words and status, flag pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ctl_q     <= '0;
            buf_q     <= '0;
            link_q    <= '0;
            stat_q    <= '0;
            irq       <= 1'b0;
            suspended <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (state)
                S_IDLE: if (poll_wr) begin
                    state     <= S_RD0;
                    suspended <= 1'b0;
                end
                S_RD0: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) state <= S_RD1;
                    else begin
                        state     <= S_IDLE;
                        suspended <= 1'b1;
                    end
                end
                S_RD1: if (mem_ack) begin
                    ctl_q <= mem_rdata;
                    state <= S_RD2;
                end
                S_RD2: if (mem_ack) begin
                    buf_q <= AW'(mem_rdata);
                    state <= S_RD3;
                end
                S_RD3: if (mem_ack) begin
                    link_q <= AW'(mem_rdata);
                    if (ctl_q[LEN_W-1:0] == '0) begin
                        stat_q <= '0;
                        state  <= S_WB;
                    end else begin
                        state <= S_MOVE;
                    end
                end
                S_MOVE: if (mv_done) begin
                    stat_q <= fmt_word;
                    state  <= S_WB;
                end
                S_WB: if (mem_ack) begin
                    irq   <= ctl_q[IRQ_BIT];
                    state <= S_RD0;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive memory and mover requests from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_off   = 4'd0;
        mem_wdata = stat_q;
        mv_req    = 1'b0;
        case (state)
            S_RD0:  mem_req = 1'b1;
            S_RD1:  begin mem_req = 1'b1; mem_off = 4'd4;  end
            S_RD2:  begin mem_req = 1'b1; mem_off = 4'd8;  end
            S_RD3:  begin mem_req = 1'b1; mem_off = 4'd12; end
            S_WB:   begin mem_req = 1'b1; mem_we = 1'b1;   end
            S_MOVE: mv_req = 1'b1;
            default: ;
        endcase
    end

    // Next pointer: link word when chained, else the following slot.
    always_comb begin
        adv     = (state == S_WB) && mem_ack;
        adv_val = ctl_q[CHAIN_BIT] ? link_q : cur_ptr + DESC_BYTES;
        mv_addr = buf_q;
        mv_len  = ctl_q[LEN_W-1:0];
        busy    = (state != S_IDLE);
    end

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_off) && $stable(mem_we) && $stable(mem_wdata));
    p_mv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req && !mv_done |=> mv_req && $stable(mv_addr) && $stable(mv_len));
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mv_req));
    p_wb_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT]);
    p_susp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !mem_req && !mv_req);
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_wb_then_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we && mem_off == 4'd0);
    p_len0_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_off == 4'd12 && mem_ack && mem_rdata == mem_rdata && ctl_q[LEN_W-1:0] == '0
        |=> !mv_req && mem_we);
endmodule

// File: rtl/tx_desc_walker.sv
// Top: transmit descriptor chain walker. Ties the pointer, sequencer and
// status formatter together and forms the byte address of each access.
// Assumes base_wr is issued only while the walk is stopped.
module tx_desc_walker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 11,
    parameter int unsigned SW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr,
    input  logic [AW-1:0]    base_addr,
    input  logic             poll_wr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             mv_req,
    output logic [AW-1:0]    mv_addr,
    output logic [LEN_W-1:0] mv_len,
    input  logic             mv_done,
    input  logic [SW-1:0]    mv_status,
    output logic             irq,
    output logic             busy,
    output logic             suspended
);
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] adv_val;
    logic          adv;
    logic [3:0]    mem_off;
    logic [31:0]   fmt_word;
    logic          load;

    // Host pointer load is accepted only when no walk is running.
    always_comb load = base_wr && !busy;

    tdw_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_val(base_addr),
        .adv(adv), .adv_val(adv_val),
        .cur(cur_ptr)
    );

    tdw_status #(.SW(SW)) u_stat (
        .raw(mv_status), .word(fmt_word)
    );

    tdw_fsm #(.AW(AW), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .poll_wr(poll_wr), .cur_ptr(cur_ptr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_done(mv_done), .fmt_word(fmt_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_off(mem_off),
        .mem_wdata(mem_wdata), .mv_req(mv_req), .mv_addr(mv_addr),
        .mv_len(mv_len), .adv(adv), .adv_val(adv_val), .irq(irq),
        .suspended(suspended), .busy(busy)
    );

    // Byte address of the word being accessed.
    always_comb mem_addr = cur_ptr + AW'(mem_off);

    p_busy_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mv_req) |-> busy);
    p_fetch_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && poll_wr |=> mem_req && !mem_we && mem_addr == $past(cur_ptr));
endmodule

// File: tb/tx_desc_walker_tb.sv
// Bench: a 64-word memory model with random stalls and a frame mover with
// random latency and status; directed rounds followed by random ones.
module tx_desc_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_addr = '0;
    logic        poll_wr = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mv_req;
    logic [31:0] mv_addr;
    logic [10:0] mv_len;
    logic        mv_done = 1'b0;
    logic [15:0] mv_status = '0;
    logic        irq, busy, suspended;

    logic [31:0] mem [0:63];
    logic        stall = 1'b0;
    logic        seen [0:15];
    logic [10:0] got_len [0:15];
    logic [15:0] got_st [0:15];
    logic        use_force = 1'b0;
    logic [15:0] force_st = '0;
    int          irq_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    int          cur_slot = 4;

    always #2 clk = ~clk;

    tx_desc_walker u_dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr),
        .poll_wr(poll_wr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mv_req(mv_req), .mv_addr(mv_addr),
        .mv_len(mv_len), .mv_done(mv_done), .mv_status(mv_status),
        .irq(irq), .busy(busy), .suspended(suspended)
    );

    // Memory model: combinational ack unless stalled, write on the edge.
    always_comb begin
        mem_ack   = mem_req && !stall;
        mem_rdata = mem[mem_addr[7:2]];
    end
    always @(posedge clk) if (mem_req && mem_we && mem_ack) mem[mem_addr[7:2]] <= mem_wdata;

    // Mover model and stall generator, driven away from the active edge.
    always @(negedge clk) begin
        logic [15:0] st;
        stall = ($urandom % 4) == 0;
        if (irq) irq_cnt++;
        if (mv_done) mv_done = 1'b0;
        else if (mv_req && ($urandom % 3) == 0) begin
            st = use_force ? force_st : 16'($urandom);
            mv_status = st;
            mv_done = 1'b1;
            seen[mv_addr[11:8]]    = 1'b1;
            got_len[mv_addr[11:8]] = mv_len;
            got_st[mv_addr[11:8]]  = st;
        end
    end

    function automatic logic [31:0] exp_wb(input logic [15:0] st);
        logic [15:0] k;
        k = st & 16'h4302;
        return {16'h0000, |k, k[14:0]};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_desc(input int slot, input logic own, input logic ie,
                            input logic chain, input logic [10:0] len, input int link);
        mem[slot*4]     = {own, 31'h0};
        mem[slot*4 + 1] = {ie, 2'b11, 4'b0, chain, 13'h0, len};
        mem[slot*4 + 2] = 32'h8000 + 32'(slot) * 32'h100;
        mem[slot*4 + 3] = 32'(link) * 32'd16;
    endtask

    // One round: k owned descriptors from cur_slot, then a host-owned stop.
    task automatic round(input int k, input int zero_idx, input logic fen, input logic [15:0] fst);
        logic [10:0] lens [0:3];
        int exp_irq;
        int to;
        int s;
        logic ie;
        exp_irq = 0;
        use_force = fen;
        force_st = fst;
        for (int i = 0; i < 16; i++) seen[i] = 1'b0;
        for (int i = 0; i < k; i++) begin
            s = (cur_slot + i) % 16;
            lens[i] = (i == zero_idx) ? 11'd0 : 11'(1 + ($urandom % 1514));
            ie = 1'($urandom);
            if (ie) exp_irq++;
            set_desc(s, 1'b1, ie, (s == 15) ? 1'b1 : 1'($urandom), lens[i], (s + 1) % 16);
        end
        s = (cur_slot + k) % 16;
        set_desc(s, 1'b0, 1'b0, 1'b0, 11'd5, 0);
        irq_cnt = 0;
        @(negedge clk) poll_wr = 1'b1;
        @(negedge clk) poll_wr = 1'b0;
        chk(mem_req && !mem_we && busy && mem_addr == 32'(cur_slot) * 16, "R2 R10 fetch at pointer",
            mem_addr, 32'(cur_slot) * 16);
        to = 0;
        while (!(suspended && !busy) && to < 4000) begin
            @(negedge clk);
            to++;
        end
        chk(to < 4000, "R3 walk suspends", 32'(to), 32'd0);
        for (int i = 0; i < k; i++) begin
            s = (cur_slot + i) % 16;
            if (lens[i] == 0) begin
                chk(!seen[s], "R5 no transfer for zero length", 32'(seen[s]), 32'd0);
                chk(mem[s*4] == 32'h0, "R5 zero-length write-back", mem[s*4], 32'h0);
            end else begin
                chk(seen[s] && got_len[s] == lens[i], "R4 mover length/address",
                    32'(got_len[s]), 32'(lens[i]));
                chk(mem[s*4] == exp_wb(got_st[s]), "R6 status write-back", mem[s*4], exp_wb(got_st[s]));
                if (fen) chk(mem[s*4] == exp_wb(fst), "R6 directed status", mem[s*4], exp_wb(fst));
            end
        end
        s = (cur_slot + k) % 16;
        chk(mem[s*4] == 32'h0 && !mem_req && !mv_req, "R3 stop descriptor untouched", mem[s*4], 32'h0);
        chk(irq_cnt == exp_irq, "R7 interrupt count", 32'(irq_cnt), 32'(exp_irq));
        cur_slot = s;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) begin seen[i] = 1'b0; got_len[i] = '0; got_st[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !suspended && !irq && !mem_req && !mv_req, "R1 reset state",
            {27'h0, busy, suspended, irq, mem_req, mv_req}, 32'h0);
        base_addr = 32'h40;
        base_wr = 1'b1;
        @(negedge clk) base_wr = 1'b0;
        round(3, 1, 1'b1, 16'h0002);   // underrun kept, R5 zero length in middle
        round(2, -1, 1'b1, 16'hFFFF);  // all masked bits, summary bit set
        round(1, -1, 1'b1, 16'hBCFD);  // no masked bits: clean status
        round(1, 0, 1'b0, 16'h0);      // single zero-length descriptor
        for (int r = 0; r < 10; r++)   // R8 random chained/sequential walks
            round(1 + int'($urandom % 4), (($urandom % 5) == 0) ? 0 : -1, 1'b0, 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule